// File: doc/BRIEF.md
# Receive Antenna Diversity Selector

This block chooses one of two receive antennas at the end of acquisition. During each antenna dwell it collects a quality figure for the antenna in use, and after the last dwell it reports which antenna is better. A configuration bit picks one of two figures. One is the per-block phase variance that the demodulator supplies. The other is the sum of correlation sidelobe magnitudes that the block builds itself from the correlator taps around the correlation peak. A lower value is better in both cases. Both figures of the comparison appear on the outputs next to the chosen antenna.

Each symbol supplies nine unsigned 8-bit correlator taps. Tap 4 is the on-time sample and taps 3 and 5 are its early and late neighbours. The six outer taps (0, 1, 2 and 6, 7, 8) are the sidelobes. Symbol sums are accumulated over at most 16 symbols per dwell. A dwell-complete strobe closes a dwell: it stores the accumulated sum and the phase variance presented with it into the slot of the antenna named by the dwell-antenna input. A start pulse clears everything and latches the configuration. A single-antenna mode skips the second dwell.

A controller with five states runs the flow. IDLE waits for the start pulse. DWELL_A and DWELL_B are the first and second dwells. DECIDE is the comparison cycle, and HOLD keeps the result. The transitions are: start pulse (any state → DWELL_A), first dwell done in dual mode (DWELL_A → DWELL_B), first dwell done in single mode (DWELL_A → DECIDE), second dwell done (DWELL_B → DECIDE), and an unconditional step (DECIDE → HOLD).

Top module: `ant_div_sel`

## Requirements
- R1: After reset, sel_ant, sel_valid, metric_a0 and metric_a1 are all 0.
- R2: With metric_sel latched as 0, the antenna whose stored phase variance is smaller is selected, and metric_a0 and metric_a1 show the two phase-variance values.
- R3: With metric_sel latched as 1, the antenna whose accumulated sidelobe sum is smaller is selected, and metric_a0 and metric_a1 show the two sums.
- R4: The sidelobe sum of a symbol is the sum of taps 0, 1, 2, 6, 7 and 8 of corr_taps, where tap i occupies bits [8i+7:8i]. Taps 3, 4 and 5 (early, on-time, late) do not contribute.
- R5: Within one dwell only the first 16 symbols with sym_valid contribute to the sum. Further symbols in that dwell are ignored, and the sum never wraps.
- R6: When the two compared metrics are equal, antenna 0 is selected.
- R7: With single_ant latched as 1, the decision follows the first dwell-complete strobe and always selects antenna 0.
- R8: sel_valid is a single-cycle pulse. It is high in the second cycle after the cycle in which the deciding dwell_done is high. sel_ant and both metrics hold their values until the next acq_start, which clears them to 0.
- R9: metric_sel and single_ant are sampled only in the acq_start cycle. Later changes do not affect the running acquisition.
- R10: A dwell's figures go to the slot named by dwell_ant (0 or 1) and are reported on metric_a0 or metric_a1 to match, whatever the order of the dwells.
- R11: dwell_done and sym_valid have no effect outside a dwell (IDLE, DECIDE, HOLD). acq_start restarts the acquisition from any state and takes priority over dwell_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acq_start | input | 1 | Start-of-acquisition pulse; clears the result and latches the configuration |
| single_ant | input | 1 | 1 = only one antenna is fitted (sampled at acq_start) |
| metric_sel | input | 1 | 0 = phase variance, 1 = sidelobe sum (sampled at acq_start) |
| sym_valid | input | 1 | A symbol's correlator taps are present |
| corr_taps | input | 72 | Nine 8-bit unsigned correlator magnitudes; tap 4 is on-time |
| dwell_done | input | 1 | Dwell-complete strobe |
| dwell_ant | input | 1 | Antenna that the completing dwell was made on |
| pvar_in | input | 16 | Phase variance of the block, taken with dwell_done |
| sel_ant | output | 1 | Chosen antenna |
| sel_valid | output | 1 | One-cycle pulse: a new decision is on sel_ant |
| metric_a0 | output | 16 | Metric of antenna 0 that was compared |
| metric_a1 | output | 16 | Metric of antenna 1 that was compared |

## Verification
Two situations are hard to reach from the ports. The first is a tie between two sidelobe sums in which the peak taps differ strongly. The second is a dwell that runs past 16 symbols, where the extra symbols carry large sidelobes that would reverse the decision if they were counted. The stimulus builds both on purpose from tap patterns whose sums are known in advance. Randomized acquisitions then follow, with random taps, lengths, dwell orders and modes and small phase-variance values that often tie. A behavioural model in the bench checks each of them cycle by cycle. Restarts in the middle of a dwell and strobes that arrive during HOLD are driven explicitly.

// File: rtl/ads_pkg.sv
package ads_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DWELL_A,
        S_DWELL_B,
        S_DECIDE,
        S_HOLD
    } ads_state_e;

    typedef struct packed {
        logic single;
        logic use_side;
    } ads_cfg_t;

endpackage

// File: rtl/ads_sidelobe_sum.sv
module ads_sidelobe_sum #(
    parameter int SAMP_W = 8,
    parameter int SIDE   = 3,
    parameter int SUM_W  = 11
) (
    input  logic [(2*SIDE+3)*SAMP_W-1:0] taps_i,
    output logic [SUM_W-1:0]             sum_o
);
    localparam int NSIDE = 2 * SIDE;

    logic [SAMP_W-1:0] side_v [NSIDE];

    // Left flank: taps 0..SIDE-1; right flank: past the three peak taps.
    for (genvar k = 0; k < NSIDE; k++) begin : g_side
        localparam int TAP = (k < SIDE) ? k : k + 3;
        assign side_v[k] = taps_i[TAP*SAMP_W +: SAMP_W];
    end

    always_comb begin
        sum_o = '0;
        for (int k = 0; k < NSIDE; k++) begin
            sum_o = sum_o + SUM_W'(side_v[k]);
        end
    end

endmodule

// File: rtl/ads_dwell_acc.sv
module ads_dwell_acc #(
    parameter int SUM_W      = 11,
    parameter int ACC_W      = 15,
    parameter int BLOCK_SYMS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             en_i,
    input  logic             sym_i,
    input  logic [SUM_W-1:0] sum_i,
    output logic [ACC_W-1:0] total_o
);
    localparam int CNT_W = $clog2(BLOCK_SYMS + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [ACC_W-1:0] acc_q;
    logic             take;

    assign take    = en_i && sym_i && (cnt_q < CNT_W'(BLOCK_SYMS));
    assign total_o = acc_q + (take ? ACC_W'(sum_i) : '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            acc_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
            acc_q <= '0;
        end else if (take) begin
            cnt_q <= cnt_q + 1'b1;
            acc_q <= total_o;
        end
    end

    // R5: block length bound and no wrap of the running sum
    p_block_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(BLOCK_SYMS));
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> (acc_q >= $past(acc_q)));

endmodule

// File: rtl/ads_pick.sv
module ads_pick #(
    parameter int MET_W = 16
) (
    input  logic             single_i,
    input  logic [MET_W-1:0] m0_i,
    input  logic [MET_W-1:0] m1_i,
    output logic             pick_o
);
    // strict less-than: equal metrics keep antenna 0
    always_comb begin
        if (single_i) pick_o = 1'b0;
        else          pick_o = (m1_i < m0_i);
    end
endmodule

// File: rtl/ads_ctrl.sv
module ads_ctrl
    import ads_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     acq_start_i,
    input  logic     single_i,
    input  logic     msel_i,
    input  logic     dwell_done_i,
    output logic     in_dwell_o,
    output logic     capture_o,
    output logic     decide_o,
    output logic     hold_o,
    output ads_cfg_t cfg_o
);
    ads_state_e state_q, state_d;
    ads_cfg_t   cfg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cfg_q   <= '0;
        end else begin
            state_q <= state_d;
            if (acq_start_i) begin
                cfg_q.single   <= single_i;
                cfg_q.use_side <= msel_i;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        if (acq_start_i) begin
            state_d = S_DWELL_A;
        end else begin
            unique case (state_q)
                S_IDLE:    state_d = S_IDLE;
                S_DWELL_A: if (dwell_done_i) state_d = cfg_q.single ? S_DECIDE : S_DWELL_B;
                S_DWELL_B: if (dwell_done_i) state_d = S_DECIDE;
                S_DECIDE:  state_d = S_HOLD;
                S_HOLD:    state_d = S_HOLD;
                default:   state_d = S_IDLE;
            endcase
        end
    end

    always_comb begin
        in_dwell_o = (state_q == S_DWELL_A) || (state_q == S_DWELL_B);
        capture_o  = in_dwell_o && dwell_done_i && !acq_start_i;
        decide_o   = (state_q == S_DECIDE);
        hold_o     = (state_q == S_HOLD);
        cfg_o      = cfg_q;
    end

    // R8: a decision cycle is always preceded by a dwell capture
    p_decide_after_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
        decide_o |-> $past(capture_o));
    // R9: configuration moves only on a start pulse
    p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !acq_start_i |=> $stable(cfg_o));

endmodule

// File: rtl/ant_div_sel.sv
module ant_div_sel
    import ads_pkg::*;
#(
    parameter int SAMP_W     = 8,
    parameter int SIDE       = 3,
    parameter int BLOCK_SYMS = 16,
    parameter int PV_W       = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          acq_start,
    input  logic                          single_ant,
    input  logic                          metric_sel,
    input  logic                          sym_valid,
    input  logic [(2*SIDE+3)*SAMP_W-1:0]  corr_taps,
    input  logic                          dwell_done,
    input  logic                          dwell_ant,
    input  logic [PV_W-1:0]               pvar_in,
    output logic                          sel_ant,
    output logic                          sel_valid,
    output logic [((SAMP_W+$clog2(2*SIDE*BLOCK_SYMS+1))>PV_W ? (SAMP_W+$clog2(2*SIDE*BLOCK_SYMS+1)) : PV_W)-1:0] metric_a0,
    output logic [((SAMP_W+$clog2(2*SIDE*BLOCK_SYMS+1))>PV_W ? (SAMP_W+$clog2(2*SIDE*BLOCK_SYMS+1)) : PV_W)-1:0] metric_a1
);
    localparam int MAXS    = (1 << SAMP_W) - 1;
    localparam int SUM_W   = $clog2(2 * SIDE * MAXS + 1);
    localparam int ACC_W   = $clog2(2 * SIDE * BLOCK_SYMS * MAXS + 1);
    localparam int MET_W   = $bits(metric_a0);
    localparam int NUM_ANT = 2;

    logic                in_dwell, capture, decide, hold;
    ads_cfg_t            cfg;
    logic [SUM_W-1:0]    sym_sum;
    logic [ACC_W-1:0]    dwell_total;
    logic [ACC_W-1:0]    side_q [NUM_ANT];
    logic [PV_W-1:0]     pv_q   [NUM_ANT];
    logic [MET_W-1:0]    cand   [NUM_ANT];
    logic                pick;

    ads_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .acq_start_i  (acq_start),
        .single_i     (single_ant),
        .msel_i       (metric_sel),
        .dwell_done_i (dwell_done),
        .in_dwell_o   (in_dwell),
        .capture_o    (capture),
        .decide_o     (decide),
        .hold_o       (hold),
        .cfg_o        (cfg)
    );

    ads_sidelobe_sum #(.SAMP_W(SAMP_W), .SIDE(SIDE), .SUM_W(SUM_W)) u_side (
        .taps_i (corr_taps),
        .sum_o  (sym_sum)
    );

    ads_dwell_acc #(.SUM_W(SUM_W), .ACC_W(ACC_W), .BLOCK_SYMS(BLOCK_SYMS)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (acq_start || capture),
        .en_i    (in_dwell),
        .sym_i   (sym_valid),
        .sum_i   (sym_sum),
        .total_o (dwell_total)
    );

    for (genvar a = 0; a < NUM_ANT; a++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                side_q[a] <= '0;
                pv_q[a]   <= '0;
            end else if (acq_start) begin
                side_q[a] <= '0;
                pv_q[a]   <= '0;
            end else if (capture && (dwell_ant == 1'(a))) begin
                side_q[a] <= dwell_total;
                pv_q[a]   <= pvar_in;
            end
        end
        assign cand[a] = cfg.use_side ? MET_W'(side_q[a]) : MET_W'(pv_q[a]);
    end

    ads_pick #(.MET_W(MET_W)) u_pick (
        .single_i (cfg.single),
        .m0_i     (cand[0]),
        .m1_i     (cand[1]),
        .pick_o   (pick)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_ant   <= 1'b0;
            sel_valid <= 1'b0;
            metric_a0 <= '0;
            metric_a1 <= '0;
        end else if (acq_start) begin
            sel_ant   <= 1'b0;
            sel_valid <= 1'b0;
            metric_a0 <= '0;
            metric_a1 <= '0;
        end else if (decide) begin
            sel_ant   <= pick;
            sel_valid <= 1'b1;
            metric_a0 <= cand[0];
            metric_a1 <= cand[1];
        end else begin
            sel_valid <= 1'b0;
        end
    end

    // R8: single-cycle pulse, two cycles after the deciding strobe
    p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |=> !sel_valid);
    p_pulse_timing_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |-> $past(dwell_done, 2));
    // R8: result frozen while holding
    p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !acq_start) |=> ($stable(sel_ant) && $stable(metric_a0) && $stable(metric_a1)));
    // R6: choosing antenna 1 needs a strictly smaller metric
    p_tie_to_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_valid && sel_ant) |-> (metric_a1 < metric_a0));
    // R7: single-antenna mode never picks antenna 1
    p_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_valid && cfg.single) |-> !sel_ant);
    // R11: strobes in HOLD produce no new decision
    p_hold_ignores_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !acq_start) |=> !sel_valid);

endmodule

// File: tb/ant_div_sel_tb_top.sv
module ant_div_sel_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acq_start = 1'b0;
    logic        single_ant = 1'b0;
    logic        metric_sel = 1'b0;
    logic        sym_valid = 1'b0;
    logic [71:0] corr_taps = '0;
    logic        dwell_done = 1'b0;
    logic        dwell_ant = 1'b0;
    logic [15:0] pvar_in = '0;
    logic        sel_ant, sel_valid;
    logic [15:0] metric_a0, metric_a1;

    int checks = 0;
    int failures = 0;
    string tag = "R1";
    bit done_flag = 0;

    always #2 clk = ~clk;

    ant_div_sel dut_i (
        .clk(clk), .rst_n(rst_n), .acq_start(acq_start), .single_ant(single_ant),
        .metric_sel(metric_sel), .sym_valid(sym_valid), .corr_taps(corr_taps),
        .dwell_done(dwell_done), .dwell_ant(dwell_ant), .pvar_in(pvar_in),
        .sel_ant(sel_ant), .sel_valid(sel_valid), .metric_a0(metric_a0), .metric_a1(metric_a1)
    );

    // ---------------- behavioural reference model ----------------
    int m_phase = 0;          // 0 idle, 1 first dwell, 2 second dwell, 3 decide, 4 hold
    int m_single = 0, m_msel = 0, m_cnt = 0, m_acc = 0;
    int m_side[2], m_pv[2];
    int e_sel = 0, e_valid = 0, e_a0 = 0, e_a1 = 0;

    function automatic int side_sum(input logic [71:0] t);
        int s = 0;
        for (int i = 0; i < 9; i++) if (i < 3 || i > 5) s += int'(t[i*8 +: 8]);
        return s;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_cnt = 0; m_acc = 0; m_single = 0; m_msel = 0;
            m_side[0] = 0; m_side[1] = 0; m_pv[0] = 0; m_pv[1] = 0;
            e_sel = 0; e_valid = 0; e_a0 = 0; e_a1 = 0;
        end else begin
            e_valid = 0;
            if (acq_start) begin
                m_phase = 1; m_single = int'(single_ant); m_msel = int'(metric_sel);
                m_cnt = 0; m_acc = 0;
                m_side[0] = 0; m_side[1] = 0; m_pv[0] = 0; m_pv[1] = 0;
                e_sel = 0; e_a0 = 0; e_a1 = 0;
            end else if (m_phase == 1 || m_phase == 2) begin
                if (sym_valid && m_cnt < 16) begin
                    m_acc += side_sum(corr_taps); m_cnt++;
                end
                if (dwell_done) begin
                    m_side[dwell_ant] = m_acc; m_pv[dwell_ant] = int'(pvar_in);
                    m_acc = 0; m_cnt = 0;
                    m_phase = (m_phase == 1 && m_single == 0) ? 2 : 3;
                end
            end else if (m_phase == 3) begin
                e_a0 = m_msel ? m_side[0] : m_pv[0];
                e_a1 = m_msel ? m_side[1] : m_pv[1];
                e_sel = (m_single == 0 && e_a1 < e_a0) ? 1 : 0;
                e_valid = 1;
                m_phase = 4;
            end
        end
    end

    task automatic chk(input string t, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", t, what, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done_flag) begin
            chk(tag, "model sel_ant", int'(sel_ant), e_sel);
            chk(tag, "model sel_valid", int'(sel_valid), e_valid);
            chk(tag, "model metric_a0", int'(metric_a0), e_a0);
            chk(tag, "model metric_a1", int'(metric_a1), e_a1);
        end
    end

    // ---------------- stimulus helpers ----------------
    function automatic logic [71:0] mk_taps(input logic [7:0] side, input logic [7:0] peak);
        logic [71:0] t;
        for (int i = 0; i < 9; i++) t[i*8 +: 8] = (i >= 3 && i <= 5) ? peak : side;
        return t;
    endfunction

    task automatic start_acq(input logic single, input logic msel);
        @(negedge clk);
        acq_start = 1'b1; single_ant = single; metric_sel = msel;
        @(negedge clk);
        acq_start = 1'b0;
    endtask

    task automatic dwell(input logic ant, input int nsym, input logic [71:0] taps, input int pv);
        for (int i = 0; i < nsym; i++) begin
            @(negedge clk);
            sym_valid = 1'b1; corr_taps = taps;
        end
        @(negedge clk);
        sym_valid = 1'b0;
        dwell_done = 1'b1; dwell_ant = ant; pvar_in = 16'(pv);
        @(negedge clk);
        dwell_done = 1'b0;
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #400000;
        if (!done_flag) begin
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // ---------------- directed and random scenarios ----------------
    initial begin
        repeat (3) @(negedge clk);
        tag = "R1";
        chk("R1", "reset sel_ant", int'(sel_ant), 0);
        chk("R1", "reset sel_valid", int'(sel_valid), 0);
        chk("R1", "reset metric_a0", int'(metric_a0), 0);
        chk("R1", "reset metric_a1", int'(metric_a1), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2: phase variance metric
        tag = "R2";
        start_acq(1'b0, 1'b0);
        dwell(1'b0, 16, mk_taps(8'd1, 8'd50), 100);
        dwell(1'b1, 16, mk_taps(8'd9, 8'd50), 40);
        @(negedge clk);
        chk("R2", "pvar pick", int'(sel_ant), 1);
        chk("R2", "pvar a0", int'(metric_a0), 100);
        chk("R2", "pvar a1", int'(metric_a1), 40);
        chk("R8", "pulse on time", int'(sel_valid), 1);
        @(negedge clk);
        chk("R8", "pulse width", int'(sel_valid), 0);

        // R3/R4: sidelobe metric, peaks large but excluded
        tag = "R3";
        start_acq(1'b0, 1'b1);
        dwell(1'b0, 16, mk_taps(8'd5, 8'd0), 1);
        dwell(1'b1, 16, mk_taps(8'd4, 8'd255), 900);
        @(negedge clk);
        chk("R3", "sidelobe pick", int'(sel_ant), 1);
        chk("R4", "sum a0 = 6*5*16", int'(metric_a0), 480);
        chk("R4", "sum a1 peaks excluded", int'(metric_a1), 384);

        // R5: symbols beyond 16 ignored
        tag = "R5";
        start_acq(1'b0, 1'b1);
        dwell(1'b0, 20, mk_taps(8'd1, 8'd0), 0);
        dwell(1'b1, 16, mk_taps(8'd1, 8'd0), 0);
        @(negedge clk);
        chk("R5", "cap at 16 symbols a0", int'(metric_a0), 96);
        chk("R6", "equal sums pick 0", int'(sel_ant), 0);
        start_acq(1'b0, 1'b1);
        dwell(1'b0, 30, mk_taps(8'd255, 8'd255), 0);
        dwell(1'b1, 16, mk_taps(8'd255, 8'd0), 0);
        @(negedge clk);
        chk("R5", "max sum no wrap", int'(metric_a0), 24480);
        chk("R6", "tie at max picks 0", int'(sel_ant), 0);

        // R6: tie on phase variance
        tag = "R6";
        start_acq(1'b0, 1'b0);
        dwell(1'b0, 16, mk_taps(8'd0, 8'd0), 77);
        dwell(1'b1, 16, mk_taps(8'd0, 8'd0), 77);
        @(negedge clk);
        chk("R6", "pvar tie", int'(sel_ant), 0);

        // R7: single antenna
        tag = "R7";
        start_acq(1'b1, 1'b0);
        dwell(1'b0, 16, mk_taps(8'd3, 8'd3), 500);
        @(negedge clk);
        chk("R7", "single valid after first dwell", int'(sel_valid), 1);
        chk("R7", "single picks 0", int'(sel_ant), 0);
        chk("R7", "single a0", int'(metric_a0), 500);

        // R8: hold then clear on start
        tag = "R8";
        start_acq(1'b0, 1'b0);
        dwell(1'b0, 16, mk_taps(8'd0, 8'd0), 30);
        dwell(1'b1, 16, mk_taps(8'd0, 8'd0), 20);
        repeat (6) @(negedge clk);
        chk("R8", "held sel", int'(sel_ant), 1);
        chk("R8", "held a0", int'(metric_a0), 30);
        start_acq(1'b0, 1'b0);
        chk("R8", "cleared sel", int'(sel_ant), 0);
        chk("R8", "cleared a1", int'(metric_a1), 0);

        // R9: config change after start has no effect
        tag = "R9";
        metric_sel = 1'b0; single_ant = 1'b0;
        start_acq(1'b0, 1'b0);
        metric_sel = 1'b1; single_ant = 1'b1;
        dwell(1'b0, 16, mk_taps(8'd0, 8'd0), 10);
        dwell(1'b1, 16, mk_taps(8'd0, 8'd0), 200);
        @(negedge clk);
        chk("R9", "still pvar metric a1", int'(metric_a1), 200);
        chk("R9", "still dual mode", int'(sel_ant), 0);

        // R10: reversed dwell order
        tag = "R10";
        start_acq(1'b0, 1'b0);
        dwell(1'b1, 16, mk_taps(8'd0, 8'd0), 11);
        dwell(1'b0, 16, mk_taps(8'd0, 8'd0), 22);
        @(negedge clk);
        chk("R10", "slot a0", int'(metric_a0), 22);
        chk("R10", "slot a1", int'(metric_a1), 11);
        chk("R10", "pick", int'(sel_ant), 1);

        // R11: strobes in HOLD ignored; restart mid-dwell
        tag = "R11";
        dwell(1'b1, 16, mk_taps(8'd0, 8'd0), 0);
        repeat (3) @(negedge clk);
        chk("R11", "hold ignores strobe a1", int'(metric_a1), 11);
        chk("R11", "hold no new pulse", int'(sel_valid), 0);
        start_acq(1'b0, 1'b0);
        dwell(1'b0, 16, mk_taps(8'd0, 8'd0), 5);
        @(negedge clk);
        acq_start = 1'b1; dwell_done = 1'b1; dwell_ant = 1'b1; pvar_in = 16'd1;
        @(negedge clk);
        acq_start = 1'b0; dwell_done = 1'b0;
        dwell(1'b0, 16, mk_taps(8'd0, 8'd0), 50);
        dwell(1'b1, 16, mk_taps(8'd0, 8'd0), 60);
        @(negedge clk);
        chk("R11", "restart discards old a0", int'(metric_a0), 50);
        chk("R11", "start beats strobe", int'(metric_a1), 60);
        chk("R11", "restart pick", int'(sel_ant), 0);

        // randomized acquisitions checked by the model
        for (int n = 0; n < 30; n++) begin
            logic first;
            logic sgl;
            tag = "R3-random";
            sgl = ($urandom % 4) == 0;
            first = 1'($urandom % 2);
            start_acq(sgl, 1'($urandom % 2));
            for (int d = 0; d < (sgl ? 1 : 2); d++) begin
                int ns;
                ns = 10 + int'($urandom % 11);
                for (int s = 0; s < ns; s++) begin
                    @(negedge clk);
                    sym_valid = 1'($urandom % 4 != 0);
                    corr_taps = {$urandom, $urandom, $urandom};
                end
                @(negedge clk);
                sym_valid = 1'b0; dwell_done = 1'b1;
                dwell_ant = (d == 0) ? first : ~first;
                pvar_in = 16'($urandom % 8);
                @(negedge clk);
                dwell_done = 1'b0;
            end
            repeat (3) @(negedge clk);
        end

        @(negedge clk);
        done_flag = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule